// File: doc/BRIEF.md
# Repeater Port Partition and Jabber Controller

One instance sits beside each port of a half-duplex repeater running at 10 or 100 Mb/s. It watches the port's carrier, its transmit activity and the collisions the port takes part in, all sampled on a bit-time tick. From these it decides whether the port is partitioned (cut off from feeding the repeater) and whether the port is jabbering (an over-long reception). It also decides when a partitioned port has behaved well enough to be reconnected.

A partitioned port is still monitored and still receives repeated traffic, but its receive data is not accepted. A jabbering port has both its receive and its transmit path closed until its carrier drops. Partition is entered after too many collision events in a row, after one collision that runs too long, or after jabber when the port runs at 100 Mb/s. Control inputs turn partition and jabber off for each speed separately and can double the limit on consecutive collisions. Generating jam and repeating packets are done elsewhere.

Top module: `rpc_top`

## Requirements
- R1: After reset, part_o and jab_o are 0, tx_en_o is 1, and all event history is clear.
- R2: State changes only on clock edges where tick_i is 1; on other edges part_o and jab_o hold, whatever the other inputs do.
- R3: An event is a run of ticks with crs_i or tx_act_i high, and it ends on the first tick with both low. When an event that saw col_i ends, the consecutive-collision count rises by one. The port is partitioned when the count reaches the limit. The limit is CC_LIM10 at 10 Mb/s (spd10_i=1) and CC_LIM100 at 100 Mb/s (spd10_i=0), and it is twice that when dbl10_i or dbl100_i respectively is 1.
- R4: An event that ends with no collision sets the consecutive-collision count to zero.
- R5: A port is partitioned on the tick that makes col_i high for more than LONG_COL_BT consecutive ticks. Exactly LONG_COL_BT ticks does not partition it.
- R6: jab_o rises on the tick on which crs_i has been high for JAB_BT consecutive ticks. It falls on the first tick with crs_i low. While jab_o is 1, tx_en_o and rx_accept_o are 0.
- R7: Jabber partitions the port at 100 Mb/s and leaves partition unchanged at 10 Mb/s.
- R8: A partitioned port reconnects when an event longer than RECON_BT ticks ends with no collision and no jabber, whether it came from receive or from transmit.
- R9: An event of RECON_BT ticks or fewer, or one that saw a collision, does not reconnect.
- R10: rx_accept_o is crs_i with partition and jabber applied. Partition does not lower tx_en_o.
- R11: When partition is off for the current speed (dpart10_i or dpart100_i is 1), part_o clears on the next tick and stays 0. When jabber is off for the current speed (djab10_i or djab100_i is 1), jab_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle bit-time strobe |
| crs_i | input | 1 | Port carrier (receive activity) |
| col_i | input | 1 | Collision involving this port |
| tx_act_i | input | 1 | Repeater is transmitting to this port |
| spd10_i | input | 1 | 1: port at 10 Mb/s, 0: 100 Mb/s |
| dpart10_i | input | 1 | Partition off at 10 Mb/s |
| dpart100_i | input | 1 | Partition off at 100 Mb/s |
| djab10_i | input | 1 | Jabber off at 10 Mb/s |
| djab100_i | input | 1 | Jabber off at 100 Mb/s |
| dbl10_i | input | 1 | Double the 10 Mb/s collision limit |
| dbl100_i | input | 1 | Double the 100 Mb/s collision limit |
| part_o | output | 1 | Port partitioned (also LED status) |
| jab_o | output | 1 | Jabber inhibit active (also LED status) |
| rx_accept_o | output | 1 | Receive data may be repeated |
| tx_en_o | output | 1 | Transmit path open |

## Verification
The bench builds the block with CC_LIM10=3, CC_LIM100=5, LONG_COL_BT=20, RECON_BT=12 and JAB_BT=60. These small values keep a few hundred cycles between every threshold. A long-collision partition, a jabber onset and its release, and a doubled limit of 6 or 10 events can then each be approached from one tick below and crossed by one tick. The same values let a long run of random carrier, collision, transmit, speed and control patterns, with gaps between ticks, visit partition entry and reconnection many times.

// File: rtl/rpc_pkg.sv
package rpc_pkg;
  typedef enum logic {SPD_100 = 1'b0, SPD_10 = 1'b1} spd_e;

  function automatic int unsigned cc_limit(input int unsigned base, input logic dbl);
    return dbl ? 2 * base : base;
  endfunction
endpackage

// File: rtl/rpc_sat_cnt.sv
module rpc_sat_cnt #(
  parameter int unsigned MAX = 15,
  localparam int unsigned W = $clog2(MAX + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] TOP = W'(MAX);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (en_i && clr_i)           cnt_q <= '0;
    else if (en_i && inc_i && cnt_q != TOP) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  assert_sat_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i && cnt_q == TOP) |=> cnt_q == TOP);
endmodule

// File: rtl/rpc_jabber.sv
module rpc_jabber #(
  parameter int unsigned JAB_BT = 65536
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic crs_i,
  input  logic en_i,
  output logic hit_o,
  output logic jab_o
);
  localparam int unsigned W = $clog2(JAB_BT + 1);
  localparam logic [W-1:0] HIT_AT = W'(JAB_BT - 1);

  logic [W-1:0] crs_len;
  logic         jab_q;

  rpc_sat_cnt #(.MAX(JAB_BT)) u_crs_len (
    .clk_i, .rst_ni, .en_i(tick_i), .clr_i(!crs_i), .inc_i(1'b1), .cnt_o(crs_len)
  );

  assign hit_o = en_i && crs_i && (crs_len >= HIT_AT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     jab_q <= 1'b0;
    else if (tick_i) jab_q <= en_i && crs_i && (jab_q || hit_o);
  end

  assign jab_o = jab_q;

  assert_jab_needs_crs_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(jab_q) |-> $past(crs_i && tick_i));
  assert_jab_drop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !crs_i) |=> !jab_q);
endmodule

// File: rtl/rpc_event_trk.sv
module rpc_event_trk #(
  parameter int unsigned RECON_BT = 512
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic act_i,
  input  logic col_i,
  input  logic jab_hit_i,
  output logic end_o,
  output logic saw_col_o,
  output logic saw_jab_o,
  output logic long_o
);
  localparam int unsigned LMAX = RECON_BT + 1;
  localparam int unsigned LW   = $clog2(LMAX + 1);
  localparam logic [LW-1:0] LONG_AT = LW'(LMAX);

  logic [LW-1:0] len;
  logic          col_q, jab_q;

  rpc_sat_cnt #(.MAX(LMAX)) u_len (
    .clk_i, .rst_ni, .en_i(tick_i), .clr_i(!act_i), .inc_i(1'b1), .cnt_o(len)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q <= 1'b0;
      jab_q <= 1'b0;
    end else if (tick_i) begin
      col_q <= act_i && (col_q || col_i);
      jab_q <= act_i && (jab_q || jab_hit_i);
    end
  end

  assign end_o     = (len != '0) && !act_i;
  assign saw_col_o = col_q;
  assign saw_jab_o = jab_q;
  assign long_o    = (len == LONG_AT);
endmodule

// File: rtl/rpc_part_fsm.sv
module rpc_part_fsm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic en_i,
  input  logic enter_i,
  input  logic recon_i,
  output logic part_o
);
  logic part_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           part_q <= 1'b0;
    else if (tick_i) begin
      if (!en_i)           part_q <= 1'b0;
      else if (enter_i)    part_q <= 1'b1;
      else if (recon_i)    part_q <= 1'b0;
    end
  end

  assign part_o = part_q;

  assert_part_tick_only_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(part_q));
  assert_part_off_dis_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !en_i) |=> !part_q);
endmodule

// File: rtl/rpc_top.sv
module rpc_top
  import rpc_pkg::*;
#(
  parameter int unsigned CC_LIM10    = 32,
  parameter int unsigned CC_LIM100   = 64,
  parameter int unsigned LONG_COL_BT = 1024,
  parameter int unsigned RECON_BT    = 512,
  parameter int unsigned JAB_BT      = 65536
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic crs_i,
  input  logic col_i,
  input  logic tx_act_i,
  input  logic spd10_i,
  input  logic dpart10_i,
  input  logic dpart100_i,
  input  logic djab10_i,
  input  logic djab100_i,
  input  logic dbl10_i,
  input  logic dbl100_i,
  output logic part_o,
  output logic jab_o,
  output logic rx_accept_o,
  output logic tx_en_o
);
  localparam int unsigned CC_MAX = 2 * ((CC_LIM10 > CC_LIM100) ? CC_LIM10 : CC_LIM100);
  localparam int unsigned CCW    = $clog2(CC_MAX + 1);
  localparam int unsigned CRW    = $clog2(LONG_COL_BT + 2);
  localparam logic [CRW-1:0] LONG_AT = CRW'(LONG_COL_BT);

  spd_e         spd;
  logic         act, part_en, jab_en, jab_hit, jab;
  logic         ev_end, ev_col, ev_jab, ev_long;
  logic [CCW-1:0] cc, lim_m1;
  logic [CRW-1:0] col_run;
  logic         long_col, cc_trip, recon, enter;

  assign spd     = spd_e'(spd10_i);
  assign act     = crs_i || tx_act_i;
  assign part_en = (spd == SPD_10) ? !dpart10_i : !dpart100_i;
  assign jab_en  = (spd == SPD_10) ? !djab10_i  : !djab100_i;
  assign lim_m1  = (spd == SPD_10) ? CCW'(cc_limit(CC_LIM10,  dbl10_i)  - 1)
                                   : CCW'(cc_limit(CC_LIM100, dbl100_i) - 1);

  rpc_jabber #(.JAB_BT(JAB_BT)) u_jab (
    .clk_i, .rst_ni, .tick_i, .crs_i, .en_i(jab_en), .hit_o(jab_hit), .jab_o(jab)
  );

  rpc_event_trk #(.RECON_BT(RECON_BT)) u_ev (
    .clk_i, .rst_ni, .tick_i, .act_i(act), .col_i, .jab_hit_i(jab_hit),
    .end_o(ev_end), .saw_col_o(ev_col), .saw_jab_o(ev_jab), .long_o(ev_long)
  );

  // consecutive colliding events; a clean event end restarts the run
  rpc_sat_cnt #(.MAX(CC_MAX)) u_cc (
    .clk_i, .rst_ni, .en_i(tick_i && ev_end), .clr_i(!ev_col), .inc_i(1'b1), .cnt_o(cc)
  );

  rpc_sat_cnt #(.MAX(LONG_COL_BT + 1)) u_col_run (
    .clk_i, .rst_ni, .en_i(tick_i), .clr_i(!col_i), .inc_i(1'b1), .cnt_o(col_run)
  );

  assign long_col = col_i && (col_run >= LONG_AT);
  assign cc_trip  = ev_end && ev_col && (cc >= lim_m1);
  assign recon    = ev_end && !ev_col && !ev_jab && ev_long;
  assign enter    = long_col || cc_trip || (jab_hit && spd == SPD_100);

  rpc_part_fsm u_part (
    .clk_i, .rst_ni, .tick_i, .en_i(part_en), .enter_i(enter), .recon_i(recon), .part_o
  );

  assign jab_o       = jab;
  assign rx_accept_o = crs_i && !part_o && !jab;
  assign tx_en_o     = !jab;

  assert_recon_at_end_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(part_o) |-> ($past(!act) || $past(!part_en)));
  assert_long_col_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && part_en && col_i && col_run >= LONG_AT) |=> part_o);
  assert_jab_stable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(jab_o));
  assert_jab10_no_part_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && spd10_i && !part_o && jab_hit && !long_col && !cc_trip) |=> !part_o);
endmodule

// File: tb/rpc_top_test.sv
module rpc_top_test;
  localparam int L10 = 3, L100 = 5, LONGC = 20, RECON = 12, JAB = 60;

  logic clk = 0, rst_n = 0;
  logic tick = 0, crs = 0, col = 0, tx = 0, spd10 = 1;
  logic dp10 = 0, dp100 = 0, dj10 = 0, dj100 = 0, d10 = 0, d100 = 0;
  logic part, jab, rxa, txe;
  int   n_chk = 0, n_bad = 0;
  string cur_req = "R1";
  bit   done = 0;

  always #10 clk = ~clk;

  rpc_top #(.CC_LIM10(L10), .CC_LIM100(L100), .LONG_COL_BT(LONGC),
            .RECON_BT(RECON), .JAB_BT(JAB)) uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .crs_i(crs), .col_i(col),
    .tx_act_i(tx), .spd10_i(spd10), .dpart10_i(dp10), .dpart100_i(dp100),
    .djab10_i(dj10), .djab100_i(dj100), .dbl10_i(d10), .dbl100_i(d100),
    .part_o(part), .jab_o(jab), .rx_accept_o(rxa), .tx_en_o(txe));

  // behavioural reference
  int m_len, m_cc, m_colrun, m_crslen;
  bit m_evcol, m_evjab, m_part, m_jab;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_len = 0; m_cc = 0; m_colrun = 0; m_crslen = 0;
      m_evcol = 0; m_evjab = 0; m_part = 0; m_jab = 0;
    end else if (tick) begin
      bit act, pe, je, hit, longc, ev_end, trip, recon, enter;
      int lim;
      act = crs | tx;
      pe  = spd10 ? !dp10 : !dp100;
      je  = spd10 ? !dj10 : !dj100;
      lim = spd10 ? (d10 ? 2*L10 : L10) : (d100 ? 2*L100 : L100);
      hit = je && crs && (m_crslen + 1 >= JAB);
      longc = col && (m_colrun + 1 > LONGC);
      ev_end = (m_len > 0) && !act;
      trip  = ev_end && m_evcol && (m_cc + 1 >= lim);
      recon = ev_end && !m_evcol && !m_evjab && (m_len > RECON);
      enter = longc || trip || (hit && !spd10);
      if (!pe) m_part = 0; else if (enter) m_part = 1; else if (recon) m_part = 0;
      m_jab = je && crs && (m_jab || hit);
      if (ev_end) m_cc = m_evcol ? m_cc + 1 : 0;
      m_evcol  = act && (m_evcol || col);
      m_evjab  = act && (m_evjab || hit);
      m_len    = act ? m_len + 1 : 0;
      m_colrun = col ? m_colrun + 1 : 0;
      m_crslen = crs ? m_crslen + 1 : 0;
    end
  end

  task automatic compare();
    bit e_rxa, e_txe;
    e_rxa = crs && !m_part && !m_jab;
    e_txe = !m_jab;
    n_chk++;
    if ({part, jab, rxa, txe} !== {m_part, m_jab, e_rxa, e_txe}) begin
      n_bad++;
      $display("FAIL %s: part/jab/rxa/txe got %b%b%b%b exp %b%b%b%b at %0t",
               cur_req, part, jab, rxa, txe, m_part, m_jab, e_rxa, e_txe, $time);
    end
  endtask

  task automatic chk(input string req, input logic got, input logic exp, input string what);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %b exp %b", req, what, got, exp);
    end
  endtask

  task automatic cyc(input logic c, input logic k, input logic t, input logic tk = 1);
    crs = c; col = k; tx = t; tick = tk;
    @(posedge clk); @(negedge clk);
    compare();
  endtask

  // n active ticks, collision on the first ncol, then one idle tick
  task automatic ev(input int n, input int ncol, input bit use_tx = 0);
    for (int i = 0; i < n; i++) cyc(!use_tx, i < ncol, use_tx);
    cyc(0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compare();
    chk("R1", part, 0, "part in reset"); chk("R1", txe, 1, "tx_en in reset");
    rst_n = 1;
    cyc(0, 0, 0);
    chk("R1", jab, 0, "jab after reset");

    cur_req = "R2";
    for (int i = 0; i < 80; i++) cyc(1, 1, 0, 0);
    chk("R2", part, 0, "no tick, no partition");
    chk("R2", jab, 0, "no tick, no jabber");
    cyc(0, 0, 0, 0); cyc(0, 0, 0);

    cur_req = "R3"; spd10 = 1;
    ev(4, 2); ev(4, 2);
    chk("R3", part, 0, "two of three");
    ev(4, 2);
    chk("R3", part, 1, "limit 3 at 10M");

    cur_req = "R10";
    cyc(1, 0, 0);
    chk("R10", rxa, 0, "partitioned rx blocked");
    chk("R10", txe, 1, "partitioned tx open");
    cyc(0, 0, 0);

    cur_req = "R9";
    ev(RECON, 0);
    chk("R9", part, 1, "short clean event");
    ev(RECON + 5, 1);
    chk("R9", part, 1, "long colliding event");
    cur_req = "R8";
    ev(RECON + 1, 0);
    chk("R8", part, 0, "reconnect on receive");

    cur_req = "R4";
    ev(4, 1); ev(4, 1); ev(3, 0); ev(4, 1); ev(4, 1);
    chk("R4", part, 0, "clean event reset count");
    ev(4, 1);
    chk("R4", part, 1, "third after reset");
    cur_req = "R8";
    ev(RECON + 3, 0, 1);
    chk("R8", part, 0, "reconnect on transmit");

    cur_req = "R3"; d10 = 1;
    for (int i = 0; i < 5; i++) ev(3, 1);
    chk("R3", part, 0, "doubled 10M: five");
    ev(3, 1);
    chk("R3", part, 1, "doubled 10M: six");
    ev(RECON + 2, 0); d10 = 0;
    spd10 = 0;
    for (int i = 0; i < 4; i++) ev(3, 1);
    chk("R3", part, 0, "100M: four");
    ev(3, 1);
    chk("R3", part, 1, "100M: five");
    ev(RECON + 2, 0);

    cur_req = "R5";
    ev(LONGC + 4, LONGC);
    chk("R5", part, 0, "collision exactly at limit");
    ev(RECON + 2, 0);
    for (int i = 0; i < LONGC; i++) cyc(1, 1, 0);
    chk("R5", part, 0, "before long collision");
    cyc(1, 1, 0);
    chk("R5", part, 1, "long collision");
    cyc(0, 0, 0); ev(RECON + 2, 0);
    chk("R5", part, 0, "recovered");

    cur_req = "R6";
    for (int i = 0; i < JAB - 1; i++) cyc(1, 0, 0);
    chk("R6", jab, 0, "one below jabber");
    cyc(1, 0, 0);
    chk("R6", jab, 1, "jabber onset");
    chk("R6", txe, 0, "jabber closes tx");
    chk("R7", part, 1, "100M jabber partitions");
    for (int i = 0; i < 10; i++) cyc(1, 0, 0);
    cyc(0, 0, 0);
    chk("R6", jab, 0, "carrier drop clears jabber");
    chk("R8", part, 1, "jabbered event does not reconnect");
    ev(RECON + 1, 0);

    cur_req = "R7"; spd10 = 1;
    for (int i = 0; i < JAB + 5; i++) cyc(1, 0, 0);
    chk("R7", jab, 1, "10M jabber");
    chk("R7", part, 0, "10M jabber no partition");
    chk("R6", rxa, 0, "jabber blocks rx");
    cyc(0, 0, 0);

    cur_req = "R11";
    ev(3, 1); ev(3, 1); ev(3, 1);
    chk("R11", part, 1, "partitioned before disable");
    dp10 = 1; cyc(0, 0, 0);
    chk("R11", part, 0, "disable clears");
    ev(3, 1); ev(3, 1); ev(3, 1); ev(3, 1);
    chk("R11", part, 0, "disabled stays clear");
    dp10 = 0; spd10 = 0; dj100 = 1;
    for (int i = 0; i < JAB + 5; i++) cyc(1, 0, 0);
    chk("R11", jab, 0, "100M jabber disabled");
    chk("R11", part, 0, "no jabber partition");
    cyc(0, 0, 0); dj100 = 0;

    cur_req = "R3";
    for (int i = 0; i < 6000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r == 0) begin
        spd10 = $urandom_range(0, 1);
        {dp10, dp100, dj10, dj100} = 4'($urandom_range(0, 15) & $urandom_range(0, 15)
                                         & $urandom_range(0, 15));
        {d10, d100} = 2'($urandom_range(0, 3));
      end
      cyc(($urandom_range(0, 9) < 6) ? crs : ($urandom_range(0, 3) == 0),
          $urandom_range(0, 29) == 0 ? ~col : col,
          $urandom_range(0, 19) == 0 ? ~tx : tx,
          $urandom_range(0, 4) != 0);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL %s: watchdog expired, got running exp finished", cur_req);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule